// File: doc/BRIEF.md
# Reload-Timer Baud Tick and Square-Wave Clock Generator

This block is the baud-generation personality of a 16-bit reload timer. When either serial clock select is set, or the square-wave output is enabled, the timer counts state times (two oscillator clocks each) from a software-supplied reload value up to all ones. On that rollover it reloads quietly, without raising any overflow status. Each rollover becomes a one-cycle tick for the receive side, the transmit side, or both. The same rollover toggles a square-wave output pin, which gives a clock with exactly 50% duty.

The external trigger pin is decoupled from the count in this mode. A falling edge on it only sets an event flag, and only when its enable bit is high. Software clears that flag with a clear strobe. The serial port that divides the ticks into bit times sits outside this block. The receive tick rate is oscillator / (2 × (65536 − reload)). The clock-out frequency is oscillator / (4 × (65536 − reload)).

Top module: `baud_clkout_gen`

## Requirements
- R1: After synchronous reset every output is 0 and the count sits at all ones. The first state time after counting becomes enabled therefore rolls over, and the first tick is visible 2 clocks after the enabling inputs are applied.
- R2: The count advances once every 2 clocks. Each rollover loads the reload value, so consecutive rollovers are exactly 2 × (65536 − reload) clocks apart.
- R3: `rx_tick` is a one-clock pulse on each rollover while `rx_clk_sel` is 1, and `tx_tick` likewise follows `tx_clk_sel`. A tick whose select is 0 stays 0.
- R4: The count moves only while `run_en` = 1, `cnt_sel` = 0 (0 means timer, 1 means external counter), and at least one of `rx_clk_sel`, `tx_clk_sel` or `clkout_en` is 1. Otherwise no tick is produced and `clk_out` holds its level.
- R5: A rollover never sets `evt_flag`.
- R6: With `trig_en` = 1, a 1-to-0 transition on `trig_in` sets `evt_flag` within 4 clocks, after a two-stage synchronizer. With `trig_en` = 0 the transition has no effect. `evt_clr` clears the flag, and a set in the same cycle wins over the clear.
- R7: A trigger edge never reloads or disturbs the count, so the rollover spacing is unchanged across it.
- R8: While `clkout_en` = 1, `clk_out` toggles on every rollover, so its high and low phases each last 2 × (65536 − reload) clocks. While `clkout_en` = 0, `clk_out` is 0.
- R9: A change of `reload_val` during a count does not affect the interval in progress. It first shapes the interval that starts at the next rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run bit: starts and stops the count |
| rx_clk_sel | input | 1 | Route rollovers to the receive tick |
| tx_clk_sel | input | 1 | Route rollovers to the transmit tick |
| clkout_en | input | 1 | Enable the square-wave output |
| cnt_sel | input | 1 | 0 = timer (counting allowed), 1 = external counter (halts this mode) |
| trig_in | input | 1 | Asynchronous external trigger pin |
| trig_en | input | 1 | Enable trigger edges to set the event flag |
| evt_clr | input | 1 | Clear strobe for the event flag |
| reload_val | input | 16 | Reload value for each rollover |
| rx_tick | output | 1 | Receive baud tick, one clock wide |
| tx_tick | output | 1 | Transmit baud tick, one clock wide |
| clk_out | output | 1 | 50% duty square-wave clock |
| evt_flag | output | 1 | Sticky trigger-event flag |

## Verification
The bench times the spacing between ticks against the reload value. It looks for two failures: a divider that counts every clock instead of every other one, and a reload off by one, which would stretch every interval by two clocks. It moves the reload value in mid-count and expects one more old-length interval. A design that loads the value immediately would shorten that interval. It fires the trigger pin during a run to catch a design that reloads on the trigger, or that lets rollovers leak into the event flag. It also freezes the count through the run bit and through the counter select, checking that the square wave holds and no tick slips through.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef struct packed {
    logic rx;
    logic tx;
    logic clk;
  } bg_route_t;
endpackage

// File: rtl/bg_prescale.sv
module bg_prescale #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic step
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !active) phase <= '0;
    else if (phase == LAST) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign step = active && (phase == LAST);
endmodule

// File: rtl/bg_reload_counter.sv
module bg_reload_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] count;

  assign wrap = step && (count == TOP);

  always_ff @(posedge clk) begin
    if (rst) count <= TOP;
    else if (wrap) count <= reload;
    else if (step) count <= count + 1'b1;
  end
endmodule

// File: rtl/bg_trig_detect.sv
module bg_trig_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= '0;
      prev <= 1'b0;
    end else begin
      sync <= {sync[STAGES-2:0], pin};
      prev <= sync[STAGES-1];
    end
  end

  assign fall = prev && !sync[STAGES-1];
endmodule

// File: rtl/baud_clkout_gen.sv
module baud_clkout_gen #(
  parameter int CNT_W      = 16,
  parameter int STATE_DIV  = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             rx_clk_sel,
  input  logic             tx_clk_sel,
  input  logic             clkout_en,
  input  logic             cnt_sel,
  input  logic             trig_in,
  input  logic             trig_en,
  input  logic             evt_clr,
  input  logic [CNT_W-1:0] reload_val,
  output logic             rx_tick,
  output logic             tx_tick,
  output logic             clk_out,
  output logic             evt_flag
);
  import bg_pkg::*;

  bg_route_t route;
  logic      active;
  logic      step;
  logic      wrap;
  logic      trig_fall;

  assign route  = '{rx: rx_clk_sel, tx: tx_clk_sel, clk: clkout_en};
  assign active = run_en && !cnt_sel && (|route);

  bg_prescale #(.DIV(STATE_DIV)) u_pre (
    .clk(clk), .rst(rst), .active(active), .step(step)
  );

  bg_reload_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .reload(reload_val), .wrap(wrap)
  );

  bg_trig_detect #(.STAGES(SYNC_DEPTH)) u_trig (
    .clk(clk), .rst(rst), .pin(trig_in), .fall(trig_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_tick <= 1'b0;
      tx_tick <= 1'b0;
    end else begin
      rx_tick <= wrap && route.rx;
      tx_tick <= wrap && route.tx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !route.clk) clk_out <= 1'b0;
    else if (wrap) clk_out <= !clk_out;
  end

  always_ff @(posedge clk) begin
    if (rst) evt_flag <= 1'b0;
    else if (trig_fall && trig_en) evt_flag <= 1'b1;
    else if (evt_clr) evt_flag <= 1'b0;
  end
endmodule

// File: rtl/bg_checker.sv
module bg_checker (
  input logic clk,
  input logic rst,
  input logic run_en,
  input logic rx_clk_sel,
  input logic tx_clk_sel,
  input logic clkout_en,
  input logic evt_clr,
  input logic rx_tick,
  input logic tx_tick,
  input logic clk_out,
  input logic evt_flag
);
  p_rx_single_r3: assert property (@(posedge clk) disable iff (rst)
    rx_tick |=> !rx_tick);

  p_tx_single_r3: assert property (@(posedge clk) disable iff (rst)
    tx_tick |=> !tx_tick);

  p_rx_routed_r3: assert property (@(posedge clk) disable iff (rst)
    rx_tick |-> $past(rx_clk_sel));

  p_tx_routed_r3: assert property (@(posedge clk) disable iff (rst)
    tx_tick |-> $past(tx_clk_sel));

  p_hold_when_stopped_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(run_en) && $past(clkout_en)) |-> $stable(clk_out));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_flag && !evt_clr) |=> evt_flag);

  p_clkout_off_r8: assert property (@(posedge clk) disable iff (rst)
    !clkout_en |=> !clk_out);
endmodule

bind baud_clkout_gen bg_checker u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .rx_clk_sel(rx_clk_sel),
  .tx_clk_sel(tx_clk_sel), .clkout_en(clkout_en), .evt_clr(evt_clr),
  .rx_tick(rx_tick), .tx_tick(tx_tick), .clk_out(clk_out), .evt_flag(evt_flag)
);

// File: tb/baud_clkout_gen_tb.sv
module baud_clkout_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 0, rx_clk_sel = 0, tx_clk_sel = 0, clkout_en = 0;
  logic        cnt_sel = 0, trig_in = 1, trig_en = 0, evt_clr = 0;
  logic [15:0] reload_val = 16'hFFF0;
  logic        rx_tick, tx_tick, clk_out, evt_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int exp_q[$];
  int cyc = 0;
  int last_rx = 0;
  bit have_last = 0;
  int rx_cnt = 0;
  int tx_cnt = 0;

  always #10 clk = ~clk;

  baud_clkout_gen u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .rx_clk_sel(rx_clk_sel),
    .tx_clk_sel(tx_clk_sel), .clkout_en(clkout_en), .cnt_sel(cnt_sel),
    .trig_in(trig_in), .trig_en(trig_en), .evt_clr(evt_clr),
    .reload_val(reload_val), .rx_tick(rx_tick), .tx_tick(tx_tick),
    .clk_out(clk_out), .evt_flag(evt_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int span(input logic [15:0] r);
    return 2 * (65536 - int'(r));
  endfunction

  // monitor: scoreboard of receive tick spacing
  always @(negedge clk) begin
    cyc++;
    if (tx_tick) tx_cnt++;
    if (rx_tick) begin
      rx_cnt++;
      if (have_last && exp_q.size() > 0) begin
        int e;
        int a;
        e = exp_q.pop_front();
        a = cyc - last_rx;
        check(a == e, "R2/R9 tick spacing", a, e);
      end
      last_rx = cyc;
      have_last = 1;
    end
  end

  task automatic push_spans(input int val, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(val);
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() > 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic wait_rx();
    @(negedge clk);
    while (!rx_tick) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int r0, t0, flips;
    logic lvl;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check({rx_tick, tx_tick, clk_out, evt_flag} == 4'b0, "R1 reset outputs",
          {rx_tick, tx_tick, clk_out, evt_flag}, 0);
    reload_val = 16'hFFF0;
    run_en = 1;
    rx_clk_sel = 1;
    @(negedge clk);
    check(rx_tick == 0, "R1 no tick after 1 clock", rx_tick, 0);
    @(negedge clk);
    check(rx_tick == 1, "R1 first rollover after 2 clocks", rx_tick, 1);

    // R2 spacing with reload 16 steps
    push_spans(span(16'hFFF0), 3);
    drain();
    check(tx_cnt == 0, "R3 tx silent when not selected", tx_cnt, 0);
    check(evt_flag == 0, "R5 rollovers leave flag clear", evt_flag, 0);

    // R9 reload change mid count
    wait_rx();
    repeat (5) @(negedge clk);
    reload_val = 16'hFFE0;
    exp_q.push_back(span(16'hFFF0));
    push_spans(span(16'hFFE0), 2);
    drain();

    // R7 / R6 trigger during run
    push_spans(span(16'hFFE0), 3);
    trig_en = 1;
    repeat (7) @(negedge clk);
    trig_in = 0;
    repeat (4) @(negedge clk);
    check(evt_flag == 1, "R6 falling edge sets flag", evt_flag, 1);
    trig_in = 1;
    drain();   // R7 spacing unchanged across trigger
    evt_clr = 1;
    @(negedge clk);
    evt_clr = 0;
    check(evt_flag == 0, "R6 clear strobe", evt_flag, 1'b0);
    trig_en = 0;
    trig_in = 0;
    repeat (6) @(negedge clk);
    check(evt_flag == 0, "R6 edge ignored when disabled", evt_flag, 0);
    trig_in = 1;
    trig_en = 1;
    repeat (6) @(negedge clk);
    check(evt_flag == 0, "R6 rising edge ignored", evt_flag, 0);
    trig_in = 0;
    evt_clr = 1;
    repeat (2) @(negedge clk);
    // set and clear compete near the edge arrival: keep clear up, set must win
    @(negedge clk);
    evt_clr = 0;
    @(negedge clk);
    check(evt_flag == 1, "R6 set wins over clear", evt_flag, 1);
    evt_clr = 1;
    @(negedge clk);
    evt_clr = 0;
    trig_in = 1;

    // R3 transmit only, window of exactly 4 periods of 64 clocks
    rx_clk_sel = 0;
    tx_clk_sel = 1;
    repeat (70) @(negedge clk);
    r0 = rx_cnt;
    t0 = tx_cnt;
    repeat (256) @(negedge clk);
    check(tx_cnt - t0 == 4, "R3 tx tick count", tx_cnt - t0, 4);
    check(rx_cnt - r0 == 0, "R3 rx silent when not selected", rx_cnt - r0, 0);

    // R8 clock out, 50% duty
    tx_clk_sel = 0;
    clkout_en = 1;
    @(negedge clk);
    while (clk_out) @(negedge clk);
    while (!clk_out) @(negedge clk);
    begin
      int hi = 0, lo = 0;
      while (clk_out && hi < 1000) begin hi++; @(negedge clk); end
      while (!clk_out && lo < 1000) begin lo++; @(negedge clk); end
      check(hi == span(16'hFFE0), "R8 high phase", hi, span(16'hFFE0));
      check(lo == span(16'hFFE0), "R8 low phase", lo, span(16'hFFE0));
    end

    // R4 run bit stops the output
    repeat (10) @(negedge clk);
    run_en = 0;
    @(negedge clk);
    lvl = clk_out;
    flips = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (clk_out != lvl) flips++;
    end
    check(flips == 0, "R4 clk_out holds when stopped", flips, 0);

    // R4 counter select halts
    run_en = 1;
    cnt_sel = 1;
    rx_clk_sel = 1;
    @(negedge clk);
    r0 = rx_cnt;
    lvl = clk_out;
    flips = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (clk_out != lvl) flips++;
    end
    check(flips == 0 && rx_cnt == r0, "R4 counter select halts", flips + rx_cnt - r0, 0);

    // R8 disable forces low
    cnt_sel = 0;
    repeat (100) @(negedge clk);
    clkout_en = 0;
    repeat (2) @(negedge clk);
    check(clk_out == 0, "R8 disabled output low", clk_out, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule